// File: doc/BRIEF.md
# Clock-Activity Power Mode Sequencer

This block decides the power state of a slave audio device that has no power pins of its own to drive. It reads one chip-enable input and watches whether the serial bit clock (SCK) is toggling. From these it settles on one of three modes: power-down, standby and normal. When the device wakes, the transmitter may not send data at once, so the block counts SCK rising edges and raises a data-valid flag only after the count for that wake path has elapsed. While data-valid is low, the transmitter sends zero words.

All logic runs on a free-running reference clock. Chip-enable and the raw SCK level each pass through a two-flop synchroniser into that domain. An SCK rising edge is detected there, so the reference clock must run at more than twice the SCK rate. SCK counts as stopped once no rising edge has been seen for `IDLE_LIMIT` reference cycles. There are three wake paths, each with its own edge count. The first wake after power-on reset uses `PWRUP_EDGES`. A restart from standby uses `RESTART_EDGES`. A re-enable from power-down uses `REEN_EDGES`. The block has no data stream of its own: every pin is a plain control or status level, and no handshake applies.

Top module: `pm_power_sequencer`

## Requirements
- R1: While `por_n` is low and on the first cycle after it rises, `mode` is 2'b00 (power-down) and `data_valid` is 0.
- R2: `mode` encodes 2'b00 as power-down, 2'b01 as standby and 2'b10 as normal. A wake in progress reports 2'b10 with `data_valid` low. 2'b11 never appears, and `data_valid` is high only while `mode` is 2'b10.
- R3: The first wake after reset begins on the first detected SCK rising edge with chip-enable high. That edge is not counted. `data_valid` rises on the `PWRUP_EDGES`-th SCK rising edge after it, and not before.
- R4: From power-down, once chip-enable is high and SCK is active, a wake begins. `data_valid` rises on the `REEN_EDGES`-th SCK rising edge of that wake.
- R5: In normal mode with `data_valid` high, if no SCK rising edge arrives for `IDLE_LIMIT` reference cycles, the mode becomes standby (2'b01) and `data_valid` drops.
- R6: In standby, the first SCK rising edge with chip-enable high starts a wake. That edge is not counted. `data_valid` rises on the `RESTART_EDGES`-th edge after it.
- R7: In normal mode or during a wake, chip-enable low makes `mode` 2'b00 within three reference cycles.
- R8: An abandoned wake restarts its count from zero on the next wake. If the abandoned wake was the first one after reset, the next wake again uses `PWRUP_EDGES`.
- R9: In standby, chip-enable low leaves the mode at standby. The next SCK rising edge then moves it to power-down.
- R10: In power-down, chip-enable high has no effect while SCK is stopped. The mode stays 2'b00 until an SCK edge makes SCK active.
- R11: A pause in SCK during a wake does not lead to standby and does not clear the edges already counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sck | input | 1 | Serial bit clock from the bus master, asynchronous |
| chip_en | input | 1 | Chip enable, asynchronous, high to enable |
| mode | output | 2 | Current power mode (R2 encoding) |
| data_valid | output | 1 | High when output words may carry samples |

## Verification
The bench targets the edge counts at their exact boundaries. It checks one edge short of each wake length and then the final edge, so a design that counts the uncounted entry edge, or uses the wrong path's length, raises `data_valid` one edge early or at the wrong total. It drops chip-enable in the middle of the power-on wake and then re-enables. A design that resumes the old count, or forgets that power-on is still pending, turns valid far too soon. It pauses SCK in the middle of a wake: a design that allows standby from any state, or clears the count on a pause, reports standby or needs extra edges. It also tries the two forbidden moves, standby to power-down on chip-enable alone and power-down to a wake without a clock. A design that honours either shows the wrong `mode` before the next SCK edge.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_STBY = 2'b01,
    PM_ON   = 2'b10
  } pm_mode_e;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAKE,
    ST_RUN,
    ST_STBY
  } pm_state_e;
endpackage

// File: rtl/pm_sync2.sv
module pm_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= din[g];
        sync_q <= meta_q;
      end
    end
    assign dout[g] = sync_q;
  end
endmodule

// File: rtl/pm_sck_monitor.sv
module pm_sck_monitor #(
  parameter int IDLE_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  output logic sck_rise,
  output logic sck_active
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam logic [IW-1:0] LIMIT = IW'(IDLE_LIMIT);

  logic          prev_q;
  logic [IW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sck_s;
  end

  assign sck_rise = sck_s & ~prev_q;

  // Idle timer saturates at the limit; reset value means "stopped".
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle_q <= LIMIT;
    else if (sck_rise)       idle_q <= '0;
    else if (idle_q != LIMIT) idle_q <= idle_q + 1'b1;
  end

  assign sck_active = (idle_q != LIMIT);
endmodule

// File: rtl/pm_wake_counter.sv
module pm_wake_counter #(
  parameter int CW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] target,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = step && (cnt_q == target - 1'b1);
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pm_pkg::*;
#(
  parameter int CW            = 19,
  parameter int PWRUP_EDGES   = 2**18,
  parameter int RESTART_EDGES = 2**14,
  parameter int REEN_EDGES    = 2**17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_s,
  input  logic          sck_rise,
  input  logic          sck_active,
  input  logic          wake_done,
  output logic          cnt_clear,
  output logic          cnt_step,
  output logic [CW-1:0] target,
  output pm_mode_e      mode,
  output logic          data_valid
);
  pm_state_e     state_q;
  logic          first_q;
  logic [CW-1:0] target_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      first_q  <= 1'b1;
      target_q <= CW'(PWRUP_EDGES);
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (en_s && sck_active) begin
            state_q  <= ST_WAKE;
            target_q <= first_q ? CW'(PWRUP_EDGES) : CW'(REEN_EDGES);
          end
        end
        ST_WAKE: begin
          if (!en_s) state_q <= ST_OFF;
          else if (wake_done) begin
            state_q <= ST_RUN;
            first_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (!en_s)            state_q <= ST_OFF;
          else if (!sck_active) state_q <= ST_STBY;
        end
        ST_STBY: begin
          // Enable is only looked at once the clock comes back.
          if (sck_rise) begin
            if (en_s) begin
              state_q  <= ST_WAKE;
              target_q <= CW'(RESTART_EDGES);
            end else begin
              state_q <= ST_OFF;
            end
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign cnt_clear  = (state_q != ST_WAKE);
  assign cnt_step   = (state_q == ST_WAKE) && sck_rise && en_s;
  assign target     = target_q;
  assign data_valid = (state_q == ST_RUN);

  always_comb begin
    unique case (state_q)
      ST_OFF:  mode = PM_OFF;
      ST_STBY: mode = PM_STBY;
      default: mode = PM_ON;
    endcase
  end
endmodule

// File: rtl/pm_power_sequencer.sv
module pm_power_sequencer
  import pm_pkg::*;
#(
  parameter int IDLE_LIMIT    = 64,
  parameter int PWRUP_EDGES   = 2**18,
  parameter int RESTART_EDGES = 2**14,
  parameter int REEN_EDGES    = 2**17
) (
  input  logic       ref_clk,
  input  logic       por_n,
  input  logic       sck,
  input  logic       chip_en,
  output logic [1:0] mode,
  output logic       data_valid
);
  localparam int MAX_A = (PWRUP_EDGES > REEN_EDGES) ? PWRUP_EDGES : REEN_EDGES;
  localparam int MAX_E = (MAX_A > RESTART_EDGES) ? MAX_A : RESTART_EDGES;
  localparam int CW    = $clog2(MAX_E + 1);

  logic          en_s, sck_s;
  logic          sck_rise, sck_active;
  logic          cnt_clear, cnt_step, wake_done;
  logic [CW-1:0] target;
  pm_mode_e      mode_e;

  pm_sync2 #(.WIDTH(2)) u_sync (
    .clk   (ref_clk),
    .rst_n (por_n),
    .din   ({chip_en, sck}),
    .dout  ({en_s, sck_s})
  );

  pm_sck_monitor #(.IDLE_LIMIT(IDLE_LIMIT)) u_mon (
    .clk        (ref_clk),
    .rst_n      (por_n),
    .sck_s      (sck_s),
    .sck_rise   (sck_rise),
    .sck_active (sck_active)
  );

  pm_wake_counter #(.CW(CW)) u_cnt (
    .clk    (ref_clk),
    .rst_n  (por_n),
    .clear  (cnt_clear),
    .step   (cnt_step),
    .target (target),
    .done   (wake_done)
  );

  pm_mode_fsm #(
    .CW            (CW),
    .PWRUP_EDGES   (PWRUP_EDGES),
    .RESTART_EDGES (RESTART_EDGES),
    .REEN_EDGES    (REEN_EDGES)
  ) u_fsm (
    .clk        (ref_clk),
    .rst_n      (por_n),
    .en_s       (en_s),
    .sck_rise   (sck_rise),
    .sck_active (sck_active),
    .wake_done  (wake_done),
    .cnt_clear  (cnt_clear),
    .cnt_step   (cnt_step),
    .target     (target),
    .mode       (mode_e),
    .data_valid (data_valid)
  );

  assign mode = mode_e;
endmodule

// File: rtl/pm_power_sequencer_chk.sv
module pm_power_sequencer_chk (
  input logic       ref_clk,
  input logic       por_n,
  input logic [1:0] mode,
  input logic       data_valid,
  input logic       en_s,
  input logic       sck_rise,
  input logic       sck_active
);
  assert_reset_state_R1: assert property (@(posedge ref_clk) disable iff (!por_n)
    $rose(por_n) |-> (mode == 2'b00 && !data_valid));

  assert_valid_in_normal_R2: assert property (@(posedge ref_clk) disable iff (!por_n)
    data_valid |-> (mode == 2'b10));

  assert_legal_mode_R2: assert property (@(posedge ref_clk) disable iff (!por_n)
    mode != 2'b11);

  // R3, R4, R6: valid only ever turns on at a counted clock edge
  assert_valid_on_edge_R3: assert property (@(posedge ref_clk) disable iff (!por_n)
    $rose(data_valid) |-> $past(sck_rise));

  assert_stby_from_run_R5: assert property (@(posedge ref_clk) disable iff (!por_n)
    (mode == 2'b01 && $past(mode) != 2'b01) |->
      ($past(mode) == 2'b10 && $past(data_valid) && !$past(sck_active)));

  assert_disable_R7: assert property (@(posedge ref_clk) disable iff (!por_n)
    (!en_s && mode != 2'b01) |=> (mode == 2'b00));

  assert_stby_hold_R9: assert property (@(posedge ref_clk) disable iff (!por_n)
    (mode == 2'b01 && !sck_rise) |=> (mode == 2'b01));

  assert_off_hold_R10: assert property (@(posedge ref_clk) disable iff (!por_n)
    (mode == 2'b00 && !(en_s && sck_active)) |=> (mode == 2'b00));
endmodule

bind pm_power_sequencer pm_power_sequencer_chk u_chk (
  .ref_clk    (ref_clk),
  .por_n      (por_n),
  .mode       (mode),
  .data_valid (data_valid),
  .en_s       (en_s),
  .sck_rise   (sck_rise),
  .sck_active (sck_active)
);

// File: tb/tb_pm_power_sequencer.sv
module tb_pm_power_sequencer;
  localparam int IL = 64;
  localparam int PW = 40;
  localparam int RS = 12;
  localparam int RE = 24;

  logic       ref_clk = 1'b0;
  logic       por_n   = 1'b0;
  logic       sck     = 1'b0;
  logic       chip_en = 1'b1;
  logic [1:0] mode;
  logic       data_valid;

  int checks = 0;
  int errors = 0;

  always #5 ref_clk = ~ref_clk;

  pm_power_sequencer #(
    .IDLE_LIMIT(IL), .PWRUP_EDGES(PW), .RESTART_EDGES(RS), .REEN_EDGES(RE)
  ) dut (
    .ref_clk(ref_clk), .por_n(por_n), .sck(sck), .chip_en(chip_en),
    .mode(mode), .data_valid(data_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1; idle(4);
      sck = 1'b0; idle(4);
    end
  endtask

  task automatic t_reset;
    por_n = 1'b0; chip_en = 1'b1; sck = 1'b0;
    idle(3);
    check("R1 mode in reset", mode, 2'b00);
    check("R1 valid in reset", data_valid, 0);
    por_n = 1'b1;
    idle(5);
    check("R10 no wake without clock", mode, 2'b00);
  endtask

  task automatic t_power_on;
    pulses(1);
    check("R2 waking reports normal", mode, 2'b10);
    check("R2 waking valid low", data_valid, 0);
    pulses(10);
    chip_en = 1'b0; idle(5);
    check("R7 disable during wake", mode, 2'b00);
    pulses(2);
    check("R7 stays off with enable low", mode, 2'b00);
    chip_en = 1'b1; idle(5);
    check("R4 wake on enable", mode, 2'b10);
    pulses(PW - 1);
    check("R8 power-on count restarted", data_valid, 0);
    pulses(1);
    check("R3 valid after power-on count", data_valid, 1);
    check("R3 mode normal", mode, 2'b10);
  endtask

  task automatic t_standby_restart;
    idle(IL + 6);
    check("R5 standby entered", mode, 2'b01);
    check("R5 valid dropped", data_valid, 0);
    pulses(1);
    check("R6 restart wake", mode, 2'b10);
    pulses(RS - 1);
    check("R6 valid low one edge short", data_valid, 0);
    pulses(1);
    check("R6 valid after restart count", data_valid, 1);
  endtask

  task automatic t_pause_in_wake;
    chip_en = 1'b0; idle(5);
    check("R7 disable from normal", mode, 2'b00);
    check("R7 valid low", data_valid, 0);
    pulses(2);
    chip_en = 1'b1; idle(5);
    pulses(10);
    idle(IL + 40);
    check("R11 no standby while waking", mode, 2'b10);
    check("R11 valid low while paused", data_valid, 0);
    pulses(RE - 11);
    check("R4 valid low one edge short", data_valid, 0);
    pulses(1);
    check("R4 valid after re-enable count", data_valid, 1);
  endtask

  task automatic t_standby_enable;
    idle(IL + 6);
    check("R5 standby again", mode, 2'b01);
    chip_en = 1'b0; idle(20);
    check("R9 standby ignores enable low", mode, 2'b01);
    pulses(1);
    check("R9 clock edge then power-down", mode, 2'b00);
    check("R9 valid low", data_valid, 0);
  endtask

  task automatic t_off_no_clock;
    idle(IL + 6);
    chip_en = 1'b1; idle(20);
    check("R10 enable without clock ignored", mode, 2'b00);
    pulses(1);
    check("R10 wake once clock runs", mode, 2'b10);
    pulses(RE - 1);
    check("R8 re-enable count after power-on done", data_valid, 0);
    pulses(1);
    check("R4 valid after re-enable", data_valid, 1);
  endtask

  initial begin
    repeat (100000) @(posedge ref_clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_power_on();
    t_standby_restart();
    t_pause_in_wake();
    t_standby_enable();
    t_off_no_clock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule